// File: doc/BRIEF.md
# Power-On Strap Capture and Test-Mode Clock Divider

This block sits beside the pads of a clock generator. Four pads are shared between configuration and clock output. While power-on reset is held, their output drivers are off. The block reads the level that a board resistor sets on each pad, or the level of the internal pull-up when no resistor is fitted. When reset ends, the block keeps that 4-bit value and turns the drivers on. From then on the pads carry clocks.

One frequency-select code selects a production test mode. In that mode every output clock group is derived from the reference input through small integer dividers:

- The reference output passes the reference unchanged.
- The 48 MHz and CPU outputs run at half the reference.
- The 24 MHz output runs at a quarter of the reference.
- The bus outputs run at a quarter or a third of the reference, chosen by the latched bus-select bit.

Outside test mode, the divided outputs stay low. The block then presents the latched frequency select and a normal-mode flag to an external synthesizer.

Top module: `strap_testclk_gen`

## Requirements
- R1: While `por_n` is low, all four `strap_oe_o` bits are 0, and they fall without waiting for a clock. After `por_n` rises between two reference edges, `strap_oe_o` becomes 4'b1111 just after the second rising reference edge, and not earlier.
- R2: The latched value is the effective pad value at that second rising edge. Bit 0 is bus-select, bit 1 is FS0, bit 2 is FS1 and bit 3 is FS2. `bus_sel_o` shows bit 0.
- R3: A pad whose `strap_drv_i` bit is 0 has no external strap. It is captured as 1 whatever its `strap_val_i` bit is. A pad whose drive bit is 1 is captured from `strap_val_i`.
- R4: Once the drivers are enabled, changes on `strap_val_i` or `strap_drv_i` have no effect on `bus_sel_o`, `fsel_o`, `test_mode_o` or the clocks until the next power-on reset.
- R5: `test_mode_o` is 1 after release exactly when {FS2,FS1,FS0} = 3'b011. `normal_mode_o` is its complement after release. Both flags are 0 during reset.
- R6: In test mode, `ref_out_o` follows `ref_clk`.
- R7: In test mode, `clk48_o` is the reference divided by 2 and `clk24_o` is the reference divided by 4, both at 50% duty.
- R8: In test mode, every bit of `cpu_clk_o` is the reference divided by 2, with all bits identical.
- R9: In test mode, every bit of `bus_clk_o` is the reference divided by 4 when bus-select is 1. When bus-select is 0 it is the reference divided by 3, high for 1.5 reference periods (50% duty).
- R10: The dividers all leave reset together. The first rising edge of the CPU, 48, 24 and bus outputs coincides with the third rising reference edge after `por_n` rises.
- R11: During reset, and at all times outside test mode, `ref_out_o`, `clk48_o`, `clk24_o`, `cpu_clk_o` and `bus_clk_o` are all 0.
- R12: `fsel_o` presents the latched {FS2,FS1,FS0} after release, in normal mode and in test mode alike.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock |
| por_n | input | 1 | Active-low power-on reset, asynchronous assert |
| strap_val_i | input | 4 | Level read from each shared pad |
| strap_drv_i | input | 4 | 1 where an external strap drives the pad, 0 where only the pull-up acts |
| strap_oe_o | output | 4 | Output driver enable for each shared pad |
| bus_sel_o | output | 1 | Latched bus-select |
| fsel_o | output | 3 | Latched {FS2,FS1,FS0} |
| test_mode_o | output | 1 | Production test mode active |
| normal_mode_o | output | 1 | Released and not in test mode |
| ref_out_o | output | 1 | Reference output (test mode) |
| clk48_o | output | 1 | Reference / 2 (test mode) |
| clk24_o | output | 1 | Reference / 4 (test mode) |
| cpu_clk_o | output | NUM_CPU | CPU clocks, reference / 2 (test mode) |
| bus_clk_o | output | NUM_BUS | Bus clocks, reference / 4 or / 3 (test mode) |

## Verification
The bench samples every output at each half reference period after release, in both halves of each period. This exposes a divide-by-3 built only on rising edges: it would show a 33% or 67% duty pattern instead of 1.5 periods high. The same sampling catches dividers that start from different counts, because they would not rise together on the third edge. Captures are run with mixed undriven pads, to catch a design that loses the pull-up value. The pads are changed after release, to catch a design that keeps sampling them. The bench also checks the exact edge where the drivers turn on, so a synchronizer stage too many or too few shifts the capture and fails, and it asserts reset mid-run to confirm the drivers drop at once.

// File: rtl/strap_pkg.sv
`timescale 1ns/1ps
package strap_pkg;
   localparam int STRAP_W = 4;

   typedef struct packed {
      logic fs2;
      logic fs1;
      logic fs0;
      logic bsel;
   } strap_t;
endpackage

// File: rtl/por_sync.sv
`timescale 1ns/1ps
module por_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   output logic rst_n_o
);
   if (STAGES < 2) begin : g_chk
      $error("por_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sh_q;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) sh_q <= '0;
      else         sh_q <= {sh_q[STAGES-2:0], 1'b1};
   end

   assign rst_n_o = sh_q[STAGES-1];
endmodule

// File: rtl/strap_latch.sv
`timescale 1ns/1ps
module strap_latch
   import strap_pkg::*;
#(
   parameter logic PULL_LEVEL = 1'b1
) (
   input  logic               clk,
   input  logic               sample_i,
   input  logic [STRAP_W-1:0] val_i,
   input  logic [STRAP_W-1:0] drv_i,
   output strap_t             strap_o
);
   logic [STRAP_W-1:0] eff;
   strap_t             cap_q;

   for (genvar i = 0; i < STRAP_W; i++) begin : g_pad
      assign eff[i] = drv_i[i] ? val_i[i] : PULL_LEVEL;
   end

   // Tracks the pads while sampling; the last sampling edge wins.
   always_ff @(posedge clk) begin
      if (sample_i) cap_q <= strap_t'(eff);
   end

   assign strap_o = cap_q;
endmodule

// File: rtl/clk_div.sv
`timescale 1ns/1ps
module clk_div #(
   parameter int DIV = 2
) (
   input  logic clk,
   input  logic en_i,
   output logic clk_o
);
   if (DIV < 2) begin : g_chk
      $error("clk_div: DIV must be at least 2");
   end

   localparam int CW = $clog2(DIV);
   localparam int HI = DIV / 2;

   logic [CW-1:0] cnt_q;
   logic          a_q;

   always_ff @(posedge clk) begin
      if (!en_i) begin
         cnt_q <= '0;
         a_q   <= 1'b0;
      end else begin
         a_q   <= (cnt_q < CW'(HI));
         cnt_q <= (cnt_q == CW'(DIV - 1)) ? '0 : cnt_q + 1'b1;
      end
   end

   if (DIV % 2 == 1) begin : g_odd
      logic b_q;
      always_ff @(negedge clk) begin
         if (!en_i) b_q <= 1'b0;
         else       b_q <= a_q;
      end
      assign clk_o = a_q | b_q;
   end else begin : g_even
      assign clk_o = a_q;
   end
endmodule

// File: rtl/strap_testclk_gen.sv
`timescale 1ns/1ps
module strap_testclk_gen
   import strap_pkg::*;
#(
   parameter int         NUM_CPU     = 8,
   parameter int         NUM_BUS     = 6,
   parameter int         SYNC_STAGES = 2,
   parameter logic [2:0] TEST_FS     = 3'b011,
   parameter int         FAST_DIV    = 2,
   parameter int         SLOW_DIV    = 4,
   parameter int         ALT_DIV     = 3
) (
   input  logic               ref_clk,
   input  logic               por_n,
   input  logic [3:0]         strap_val_i,
   input  logic [3:0]         strap_drv_i,
   output logic [3:0]         strap_oe_o,
   output logic               bus_sel_o,
   output logic [2:0]         fsel_o,
   output logic               test_mode_o,
   output logic               normal_mode_o,
   output logic               ref_out_o,
   output logic               clk48_o,
   output logic               clk24_o,
   output logic [NUM_CPU-1:0] cpu_clk_o,
   output logic [NUM_BUS-1:0] bus_clk_o
);
   if (NUM_CPU < 1 || NUM_BUS < 1) begin : g_chk_cnt
      $error("strap_testclk_gen: output group counts must be positive");
   end
   if (STRAP_W != 4) begin : g_chk_w
      $error("strap_testclk_gen: strap width must be 4");
   end

   logic   rst_n;
   strap_t strap;
   logic   tm_hit;
   logic   run;
   logic   d_fast, d_slow, d_alt, bus_div;

   por_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (ref_clk),
      .arst_n  (por_n),
      .rst_n_o (rst_n)
   );

   strap_latch #(.PULL_LEVEL(1'b1)) u_latch (
      .clk      (ref_clk),
      .sample_i (~rst_n),
      .val_i    (strap_val_i),
      .drv_i    (strap_drv_i),
      .strap_o  (strap)
   );

   assign tm_hit = ({strap.fs2, strap.fs1, strap.fs0} == TEST_FS);
   assign run    = rst_n & tm_hit;

   clk_div #(.DIV(FAST_DIV)) u_div_fast (.clk(ref_clk), .en_i(run), .clk_o(d_fast));
   clk_div #(.DIV(SLOW_DIV)) u_div_slow (.clk(ref_clk), .en_i(run), .clk_o(d_slow));
   clk_div #(.DIV(ALT_DIV))  u_div_alt  (.clk(ref_clk), .en_i(run), .clk_o(d_alt));

   assign bus_div = strap.bsel ? d_slow : d_alt;

   assign strap_oe_o    = {4{rst_n}};
   assign bus_sel_o     = strap.bsel;
   assign fsel_o        = {strap.fs2, strap.fs1, strap.fs0};
   assign test_mode_o   = run;
   assign normal_mode_o = rst_n & ~tm_hit;

   // Gated by run so outputs drop at once when reset asserts.
   assign ref_out_o = run & ref_clk;
   assign clk48_o   = run & d_fast;
   assign clk24_o   = run & d_slow;

   for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
      assign cpu_clk_o[c] = run & d_fast;
   end
   for (genvar b = 0; b < NUM_BUS; b++) begin : g_bus
      assign bus_clk_o[b] = run & bus_div;
   end
endmodule

// File: rtl/strap_testclk_sva.sv
`timescale 1ns/1ps
module strap_testclk_sva #(
   parameter int NUM_CPU = 8,
   parameter int NUM_BUS = 6
) (
   input logic               ref_clk,
   input logic               por_n,
   input logic [3:0]         strap_oe_o,
   input logic               bus_sel_o,
   input logic [2:0]         fsel_o,
   input logic               test_mode_o,
   input logic               normal_mode_o,
   input logic               clk48_o,
   input logic               clk24_o,
   input logic               ref_out_o,
   input logic [NUM_CPU-1:0] cpu_clk_o,
   input logic [NUM_BUS-1:0] bus_clk_o
);
   // R1: drivers off while power-on reset is low
   always @(posedge ref_clk) begin
      if (por_n === 1'b0) begin
         p_oe_off_r1: assert (strap_oe_o == 4'b0000);
      end
   end

   // R4: latched straps stay fixed once drivers are on
   p_hold_r4: assert property (@(posedge ref_clk) disable iff (!por_n)
      (strap_oe_o[0] && $past(strap_oe_o[0])) |-> $stable({bus_sel_o, fsel_o}));

   // R5: exactly one mode flag after release
   p_mode_excl_r5: assert property (@(posedge ref_clk) disable iff (!por_n)
      strap_oe_o[0] |-> (test_mode_o ^ normal_mode_o));

   // R7: the half-rate clock toggles on every reference edge in test mode
   p_div2_r7: assert property (@(posedge ref_clk) disable iff (!por_n)
      (test_mode_o && $past(test_mode_o && strap_oe_o[0])) |-> (clk48_o != $past(clk48_o)));

   // R8: CPU group matches the half-rate clock
   p_cpu_match_r8: assert property (@(posedge ref_clk) disable iff (!por_n)
      cpu_clk_o == {NUM_CPU{clk48_o}});

   // R11: no clock activity outside test mode
   p_idle_low_r11: assert property (@(posedge ref_clk) disable iff (!por_n)
      !test_mode_o |-> ({ref_out_o, clk48_o, clk24_o} == 3'b000 && cpu_clk_o == '0 && bus_clk_o == '0));
endmodule

bind strap_testclk_gen strap_testclk_sva #(.NUM_CPU(NUM_CPU), .NUM_BUS(NUM_BUS)) u_sva (
   .ref_clk       (ref_clk),
   .por_n         (por_n),
   .strap_oe_o    (strap_oe_o),
   .bus_sel_o     (bus_sel_o),
   .fsel_o        (fsel_o),
   .test_mode_o   (test_mode_o),
   .normal_mode_o (normal_mode_o),
   .clk48_o       (clk48_o),
   .clk24_o       (clk24_o),
   .ref_out_o     (ref_out_o),
   .cpu_clk_o     (cpu_clk_o),
   .bus_clk_o     (bus_clk_o)
);

// File: tb/strap_testclk_gen_tb.sv
`timescale 1ns/1ps
module strap_testclk_gen_tb;
   localparam int NC = 8;
   localparam int NB = 6;

   logic          ref_clk = 1'b0;
   logic          por_n   = 1'b0;
   logic [3:0]    val     = 4'b0;
   logic [3:0]    drv     = 4'b0;
   logic [3:0]    oe;
   logic          bsel, tm, nm, refo, c48, c24;
   logic [2:0]    fsel;
   logic [NC-1:0] cpu;
   logic [NB-1:0] bus;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #5 ref_clk = ~ref_clk;

   strap_testclk_gen #(.NUM_CPU(NC), .NUM_BUS(NB)) u_dut (
      .ref_clk(ref_clk), .por_n(por_n), .strap_val_i(val), .strap_drv_i(drv),
      .strap_oe_o(oe), .bus_sel_o(bsel), .fsel_o(fsel), .test_mode_o(tm),
      .normal_mode_o(nm), .ref_out_o(refo), .clk48_o(c48), .clk24_o(c24),
      .cpu_clk_o(cpu), .bus_clk_o(bus)
   );

   // {drv, val, exp_test, exp_bsel, exp_fsel}
   localparam logic [12:0] VEC [0:7] = '{
      13'b1111_0111_1_1_011,
      13'b1111_0110_1_0_011,
      13'b1000_0000_1_1_011,
      13'b1001_0000_1_0_011,
      13'b0000_0000_0_1_111,
      13'b1111_0101_0_1_010,
      13'b1111_1011_0_1_101,
      13'b1111_0011_0_1_001
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   // Half-period index h since the first divider edge; high for the first div halves.
   function automatic logic wave(input int div, input int h);
      return (h % (2 * div)) < div;
   endfunction

   task automatic check_clocks(input logic et, input logic eb, input int h);
      if (et) begin
         chk("R6 ref", 32'(refo), 32'(wave(1, h)));
         chk("R7 clk48", 32'(c48), 32'(wave(2, h)));
         chk("R7 clk24", 32'(c24), 32'(wave(4, h)));
         chk("R8 cpu", 32'(cpu), 32'({NC{wave(2, h)}}));
         chk("R9 bus", 32'(bus), 32'({NB{wave(eb ? 4 : 3, h)}}));
      end else begin
         chk("R11 idle", 32'({refo, c48, c24, cpu, bus}), 32'd0);
      end
   endtask

   task automatic run_vec(input logic [12:0] v);
      logic       et = v[4];
      logic       eb = v[3];
      logic [2:0] ef = v[2:0];
      por_n = 1'b0;
      drv   = v[12:9];
      val   = v[8:5];
      repeat (3) @(posedge ref_clk);
      #3;
      chk("R1 oe in reset", 32'(oe), 32'd0);
      chk("R11 clocks in reset", 32'({refo, c48, c24, cpu, bus}), 32'd0);
      chk("R5 flags in reset", 32'({tm, nm}), 32'd0);
      por_n = 1'b1;
      @(posedge ref_clk); #1;
      chk("R1 oe after 1 edge", 32'(oe), 32'd0);
      @(posedge ref_clk); #1;
      chk("R1 oe after 2 edges", 32'(oe), 32'hF);
      chk("R2 R3 bus_sel", 32'(bsel), 32'(eb));
      chk("R12 fsel", 32'(fsel), 32'(ef));
      chk("R5 flags", 32'({tm, nm}), 32'({et, ~et}));
      // R4: disturb the pads once the drivers are on
      drv = 4'b1111;
      val = ~v[8:5];
      for (int k = 1; k <= 12; k++) begin
         @(posedge ref_clk); #2;
         if (k == 1 && et) begin
            // R10: every divided group rises on the third edge after release
            chk("R10 aligned rise", 32'({c48, c24, cpu[0], bus[0]}), 32'hF);
         end
         check_clocks(et, eb, 2 * (k - 1));
         #5;
         check_clocks(et, eb, 2 * (k - 1) + 1);
      end
      chk("R4 held", 32'({bsel, fsel, tm}), 32'({eb, ef, et}));
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 8; i++) run_vec(VEC[i]);

      // R3: undriven pads read 1 even when their level input says 0
      run_vec(13'b0001_0000_0_0_111);

      // R1: asynchronous reset in the middle of a test-mode run
      run_vec(VEC[1]);
      @(negedge ref_clk); #1;
      por_n = 1'b0;
      #1;
      chk("R1 async oe drop", 32'(oe), 32'd0);
      chk("R11 async clocks low", 32'({refo, c48, c24, cpu, bus}), 32'd0);
      chk("R5 async flags low", 32'({tm, nm}), 32'd0);

      // R2: recapture after a new reset picks up the new straps
      run_vec(VEC[4]);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule